// File: doc/BRIEF.md
# Interleaved Integer Matrix Product Engine

The engine multiplies two 16x16 matrices of signed 16-bit integers held in an operand memory and writes the 256 elements of the product matrix to a result memory. Each result element C[i][j] is the inner product of row i of A with column j of B. The sum is taken over 16 terms. The adder that accumulates these sums has a fixed latency of seven cycles. A single running sum could therefore take a new term only every seventh cycle. The engine hides this latency by keeping seven inner products in flight and rotating among them, one term per cycle. Each partial sum re-enters the adder on the same cycle that its previous value leaves it.

Outputs are worked in groups of seven consecutive row-major result indices. Within a group, the engine steps through the k index. For each k it issues one read to each of the seven outputs in turn. 256 is not a multiple of seven, so the final group covers only four real outputs. Its three surplus lanes still take their issue slots, which keeps the rotation regular, but their results are never written. A one-cycle start pulse launches a job. A one-cycle done pulse closes it.

Top module: `mm_engine`

## Requirements
- R1: Each written C[i][j] equals the exact sum over k of A[i][k]*B[k][j]. Operands are signed 16-bit. The result is a signed 40-bit value.
- R2: Read data arrives on a_data_i/b_data_i one cycle after op_re_o presents an address. A[i][k] is read at word address i*16+k. B[k][j] is read at word address 256+k*16+j.
- R3: Sums of extreme operands, such as sixteen terms of (-32768)*(-32768) = 2^34, are returned without overflow.
- R4: Once a job is accepted, op_re_o stays high for exactly 37*16*7 = 4144 consecutive cycles, starting the cycle after the accepted start pulse. This is one operand pair per cycle.
- R5: Read number n of a job, counted from 0, follows a fixed order. Let g=n/112, k=(n mod 112)/7 and s=n mod 7. The output index is o=7g+s, with i=(o/16) mod 16 and j=o mod 16.
- R6: Exactly 256 results are written per job, on c_addr_o = 16*i+j, in strictly ascending order. Surplus lanes of the last group write nothing.
- R7: An element is written 9 cycles after the read of its last term is issued. The first write therefore comes 114 cycles after the first read cycle.
- R8: done_o is high for exactly one cycle, directly after the write to address 255. This is 4150 cycles after the first read cycle.
- R9: A start pulse that arrives between an accepted start and the following done has no effect on the reads, the writes or the done timing.
- R10: After reset, op_re_o, c_we_o and done_o are low until a start pulse is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launches a job when the engine is idle |
| op_re_o | output | 1 | Operand read enable |
| a_addr_o | output | 9 | Word address of the A operand |
| b_addr_o | output | 9 | Word address of the B operand |
| a_data_i | input | 16 | A operand, one cycle after its address |
| b_data_i | input | 16 | B operand, one cycle after its address |
| c_we_o | output | 1 | Result write enable |
| c_addr_o | output | 8 | Result address, row-major 16*i+j |
| c_data_o | output | 40 | Signed result value |
| done_o | output | 1 | One-cycle pulse after the final write |

## Verification
Some properties are checked on every cycle:
- A reads stay below address 256 and B reads at or above it.
- Result writes climb one address at a time.
- Each job closes with exactly 256 writes and 4144 reads.
- done_o is a single pulse that follows the write to address 255.

Only the bench scenarios can show the rest. These are the arithmetic of each inner product under varied, identity-like and extreme operand patterns, the exact read order of the rotation, the 114- and 4150-cycle offsets, and the ignoring of a start pulse during a job.

// File: rtl/mm_pkg.sv
package mm_pkg;
  localparam int unsigned DIM     = 16;
  localparam int unsigned OP_W    = 16;
  localparam int unsigned ACC_W   = 40;
  localparam int unsigned ADD_LAT = 7;
  localparam int unsigned A_BASE  = 0;
  localparam int unsigned B_BASE  = 256;
  localparam int unsigned ADDR_W  = 9;
  localparam int unsigned KW      = $clog2(DIM);
  localparam int unsigned CW      = 2 * KW;

  typedef struct packed {
    logic          first;
    logic          last;
    logic          live;
    logic [CW-1:0] c_idx;
  } mac_tag_t;
endpackage

// File: rtl/mm_addr_gen.sv
module mm_addr_gen
  import mm_pkg::*;
#(
  parameter int unsigned DIM_P = DIM,
  parameter int unsigned LAT_P = ADD_LAT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] a_addr_o,
  output logic [ADDR_W-1:0] b_addr_o,
  output mac_tag_t          tag_o
);
  localparam int unsigned NOUT = DIM_P * DIM_P;
  localparam int unsigned NGRP = (NOUT + LAT_P - 1) / LAT_P;
  localparam int unsigned SW   = $clog2(LAT_P);
  localparam int unsigned GW   = $clog2(NGRP);
  localparam int unsigned OW   = $clog2(NGRP * LAT_P);

  logic          run_q;
  logic [SW-1:0] s_q;
  logic [KW-1:0] k_q;
  logic [GW-1:0] g_q;
  logic          end_s, end_k, end_g;
  logic [OW-1:0] o_idx;
  logic [KW-1:0] row, col;

  assign end_s = (s_q == SW'(LAT_P - 1));
  assign end_k = (k_q == KW'(DIM_P - 1));
  assign end_g = (g_q == GW'(NGRP - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      s_q   <= '0;
      k_q   <= '0;
      g_q   <= '0;
    end else if (!run_q) begin
      run_q <= start_i;
      s_q   <= '0;
      k_q   <= '0;
      g_q   <= '0;
    end else if (end_s) begin
      s_q <= '0;
      if (end_k) begin
        k_q <= '0;
        if (end_g) run_q <= 1'b0;
        else       g_q   <= g_q + 1'b1;
      end else begin
        k_q <= k_q + 1'b1;
      end
    end else begin
      s_q <= s_q + 1'b1;
    end
  end

  // lane s of group g owns output 7g+s; surplus lanes wrap and are masked
  assign o_idx = OW'(g_q) * OW'(LAT_P) + OW'(s_q);
  assign row   = o_idx[CW-1:KW];
  assign col   = o_idx[KW-1:0];

  assign valid_o     = run_q;
  assign a_addr_o    = ADDR_W'(A_BASE) + ADDR_W'({row, k_q});
  assign b_addr_o    = ADDR_W'(B_BASE) + ADDR_W'({k_q, col});
  assign tag_o.first = (k_q == '0);
  assign tag_o.last  = end_k;
  assign tag_o.live  = (o_idx < OW'(NOUT));
  assign tag_o.c_idx = o_idx[CW-1:0];
endmodule

// File: rtl/mm_mac_pipe.sv
module mm_mac_pipe
  import mm_pkg::*;
#(
  parameter int unsigned LAT_P = ADD_LAT
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   valid_i,
  input  mac_tag_t               tag_i,
  input  logic signed [OP_W-1:0] a_i,
  input  logic signed [OP_W-1:0] b_i,
  output logic                   wr_o,
  output logic [CW-1:0]          wr_addr_o,
  output logic [ACC_W-1:0]       wr_data_o
);
  localparam int unsigned PW = 2 * OP_W;

  logic                    v_d1, v_p;
  mac_tag_t                tag_d1, tag_p;
  logic signed [PW-1:0]    prod_d, prod_q;
  logic signed [ACC_W-1:0] prod_ext, sum_d;
  logic                    v_q   [LAT_P];
  mac_tag_t                tag_q [LAT_P];
  logic signed [ACC_W-1:0] acc_q [LAT_P];

  assign prod_d = a_i * b_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_d1 <= 1'b0;
      v_p  <= 1'b0;
    end else begin
      v_d1 <= valid_i;
      v_p  <= v_d1;
    end
  end

  always_ff @(posedge clk_i) begin
    tag_d1 <= tag_i;
    tag_p  <= tag_d1;
    prod_q <= prod_d;
  end

  // feedback from the adder tail belongs to the same lane, LAT_P cycles older
  assign prod_ext = {{(ACC_W - PW){prod_q[PW-1]}}, prod_q};
  assign sum_d    = prod_ext + (tag_p.first ? '0 : acc_q[LAT_P-1]);

  for (genvar st = 0; st < LAT_P; st++) begin : g_add
    if (st == 0) begin : g_head
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) v_q[0] <= 1'b0;
        else         v_q[0] <= v_p;
      end
      always_ff @(posedge clk_i) begin
        acc_q[0] <= sum_d;
        tag_q[0] <= tag_p;
      end
    end else begin : g_body
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) v_q[st] <= 1'b0;
        else         v_q[st] <= v_q[st-1];
      end
      always_ff @(posedge clk_i) begin
        acc_q[st] <= acc_q[st-1];
        tag_q[st] <= tag_q[st-1];
      end
    end
  end

  assign wr_o      = v_q[LAT_P-1] & tag_q[LAT_P-1].last & tag_q[LAT_P-1].live;
  assign wr_addr_o = tag_q[LAT_P-1].c_idx;
  assign wr_data_o = acc_q[LAT_P-1];
endmodule

// File: rtl/mm_engine.sv
module mm_engine
  import mm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              op_re_o,
  output logic [ADDR_W-1:0] a_addr_o,
  output logic [ADDR_W-1:0] b_addr_o,
  input  logic [OP_W-1:0]   a_data_i,
  input  logic [OP_W-1:0]   b_data_i,
  output logic              c_we_o,
  output logic [CW-1:0]     c_addr_o,
  output logic [ACC_W-1:0]  c_data_o,
  output logic              done_o
);
  logic     busy_q, done_q, go;
  mac_tag_t tag;

  // a job stays busy until its done pulse, so early starts are dropped
  assign go = start_i & ~busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= c_we_o & (c_addr_o == '1);
      if (go)          busy_q <= 1'b1;
      else if (done_q) busy_q <= 1'b0;
    end
  end

  mm_addr_gen #(.DIM_P(DIM), .LAT_P(ADD_LAT)) u_agen (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (go),
    .valid_o  (op_re_o),
    .a_addr_o (a_addr_o),
    .b_addr_o (b_addr_o),
    .tag_o    (tag)
  );

  mm_mac_pipe #(.LAT_P(ADD_LAT)) u_mac (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (op_re_o),
    .tag_i     (tag),
    .a_i       (a_data_i),
    .b_i       (b_data_i),
    .wr_o      (c_we_o),
    .wr_addr_o (c_addr_o),
    .wr_data_o (c_data_o)
  );

  assign done_o = done_q;
endmodule

// File: rtl/mm_engine_chk.sv
module mm_engine_chk
  import mm_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              op_re_o,
  input logic [ADDR_W-1:0] a_addr_o,
  input logic [ADDR_W-1:0] b_addr_o,
  input logic              c_we_o,
  input logic [CW-1:0]     c_addr_o,
  input logic              done_o
);
  localparam int unsigned NOUT  = DIM * DIM;
  localparam int unsigned NREAD = ((NOUT + ADD_LAT - 1) / ADD_LAT) * DIM * ADD_LAT;

  logic [15:0] rd_cnt_q;
  logic [15:0] wr_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_cnt_q <= '0;
      wr_cnt_q <= '0;
    end else if (done_o) begin
      rd_cnt_q <= '0;
      wr_cnt_q <= '0;
    end else begin
      rd_cnt_q <= rd_cnt_q + 16'(op_re_o);
      wr_cnt_q <= wr_cnt_q + 16'(c_we_o);
    end
  end

  a_r2_addr_split: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_re_o |-> (a_addr_o < ADDR_W'(B_BASE)) && (b_addr_o >= ADDR_W'(B_BASE)));

  a_r6_write_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    c_we_o |-> (16'(c_addr_o) == wr_cnt_q));

  a_r6_write_total: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (wr_cnt_q == 16'(NOUT)));

  a_r4_read_total: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (rd_cnt_q == 16'(NREAD)));

  a_r8_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r8_done_after_final: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(c_we_o) && ($past(c_addr_o) == CW'(NOUT - 1))));
endmodule

bind mm_engine mm_engine_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .op_re_o  (op_re_o),
  .a_addr_o (a_addr_o),
  .b_addr_o (b_addr_o),
  .c_we_o   (c_we_o),
  .c_addr_o (c_addr_o),
  .done_o   (done_o)
);

// File: tb/mm_engine_tb_top.sv
module mm_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        op_re, c_we, done;
  logic [8:0]  a_addr, b_addr;
  logic [15:0] a_d, b_d;
  logic [7:0]  c_addr;
  logic [39:0] c_data;

  typedef struct packed {
    logic [7:0]  addr;
    logic [39:0] data;
  } wr_item_t;

  logic signed [15:0] mem [512];
  wr_item_t exp_q [$];

  int drv_chk = 0, drv_err = 0;
  int mon_chk = 0, mon_err = 0;
  int cyc = 0, first_rd_cyc = 0;
  int rd_run = 0, wr_run = 0, addr_err = 0;
  int first_wr_off = -1, done_off = -1, rd_last = 0, wr_last = 0, done_cnt = 0;
  int addr_err_last = 0;

  always #10 clk = ~clk;

  mm_engine dut_i (
    .clk_i (clk), .rst_ni (rst_n), .start_i (start),
    .op_re_o (op_re), .a_addr_o (a_addr), .b_addr_o (b_addr),
    .a_data_i (a_d), .b_data_i (b_d),
    .c_we_o (c_we), .c_addr_o (c_addr), .c_data_o (c_data),
    .done_o (done)
  );

  always @(posedge clk) begin
    if (op_re) begin
      a_d <= mem[a_addr];
      b_d <= mem[b_addr];
    end
  end

  // monitor: read-order check, scoreboard pop, timing capture
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (op_re) begin
      int n, g, k, s, o, ea, eb;
      n = rd_run;
      g = n / 112; k = (n % 112) / 7; s = n % 7;
      o = g * 7 + s;
      ea = ((o / 16) % 16) * 16 + k;
      eb = 256 + k * 16 + (o % 16);
      if (rd_run == 0) first_rd_cyc = cyc;
      if (int'(a_addr) != ea || int'(b_addr) != eb) begin
        if (addr_err == 0)
          $display("FAIL R5 read %0d: a=%0d b=%0d expected a=%0d b=%0d", n, a_addr, b_addr, ea, eb);
        addr_err = addr_err + 1;
      end
      rd_run = rd_run + 1;
    end
    if (c_we) begin
      if (wr_run == 0) first_wr_off = cyc - first_rd_cyc;
      wr_run = wr_run + 1;
      mon_chk = mon_chk + 1;
      if (exp_q.size() == 0) begin
        mon_err = mon_err + 1;
        $display("FAIL R6 extra write addr=%0d data=%0d expected none", c_addr, $signed(c_data));
      end else begin
        wr_item_t e;
        e = exp_q.pop_front();
        if (c_addr != e.addr || c_data != e.data) begin
          mon_err = mon_err + 1;
          $display("FAIL R1 write addr=%0d data=%0d expected addr=%0d data=%0d",
                   c_addr, $signed(c_data), e.addr, $signed(e.data));
        end
      end
    end
    if (done) begin
      done_off = cyc - first_rd_cyc;
      rd_last = rd_run; wr_last = wr_run; addr_err_last = addr_err;
      done_cnt = done_cnt + 1;
      rd_run = 0; wr_run = 0; addr_err = 0;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    drv_chk = drv_chk + 1;
    if (!ok) begin
      drv_err = drv_err + 1;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic signed [15:0] pat(input int mode, input int mat, input int r, input int c);
    case (mode)
      0: return 16'(((r * 37 + c * 11 + mat * 5) % 211) - 105);
      1: return 16'sh8000;
      2: return (mat == 0) ? ((r == c) ? 16'sd1 : 16'sd0) : 16'(r * 16 + c - 128);
      default: return 16'(((r * 13 + c * 29 + 7) % 4001) * ((r + c) % 2 ? -8 : 8));
    endcase
  endfunction

  // driver: load memory, push expected results, launch, wait, check timing
  task automatic run_job(input int mode, input bit poke_start, input string tag);
    int prev_done, wait_cnt;
    for (int r = 0; r < 16; r++)
      for (int c = 0; c < 16; c++) begin
        mem[r * 16 + c]       = pat(mode, 0, r, c);
        mem[256 + r * 16 + c] = pat(mode, 1, r, c);
      end
    for (int i = 0; i < 16; i++)
      for (int j = 0; j < 16; j++) begin
        longint acc = 0;
        wr_item_t it;
        for (int k = 0; k < 16; k++)
          acc += longint'(mem[i * 16 + k]) * longint'(mem[256 + k * 16 + j]);
        it.addr = 8'(i * 16 + j);
        it.data = 40'(acc);
        exp_q.push_back(it);
      end
    prev_done = done_cnt;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    if (poke_start) begin
      repeat (500) @(negedge clk);
      start = 1'b1;                     // R9: must be ignored mid-job
      @(negedge clk) start = 1'b0;
    end
    wait_cnt = 0;
    while (done_cnt == prev_done && wait_cnt < 6000) begin
      @(negedge clk);
      wait_cnt++;
    end
    check(done_cnt == prev_done + 1, {"R8 done seen ", tag}, done_cnt - prev_done, 1);
    repeat (3) @(negedge clk);
    check(done_cnt == prev_done + 1, {"R8 single done pulse ", tag}, done_cnt - prev_done, 1);
    check(done_off == 4150, {"R8 done offset ", tag}, done_off, 4150);
    check(first_wr_off == 114, {"R7 first write offset ", tag}, first_wr_off, 114);
    check(rd_last == 4144, {"R4 read cycles ", tag}, rd_last, 4144);
    check(addr_err_last == 0, {"R5 read order errors ", tag}, addr_err_last, 0);
    check(wr_last == 256, {"R6 write count ", tag}, wr_last, 256);
    check(exp_q.size() == 0, {"R1 results left ", tag}, exp_q.size(), 0);
    exp_q.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!op_re, "R10 op_re idle", int'(op_re), 0);
    check(!c_we, "R10 c_we idle", int'(c_we), 0);
    check(!done, "R10 done idle", int'(done), 0);
    run_job(0, 1'b0, "mixed");
    run_job(1, 1'b0, "R3 extreme");
    run_job(2, 1'b0, "R2 identity");
    run_job(3, 1'b1, "R9 restart ignored");
    $display("Simulation finished: %0d checks, %0d errors", drv_chk + mon_chk, drv_err + mon_err);
    $finish;
  end
endmodule